// File: doc/BRIEF.md
# Bit Shift Register with Status Flags

This block is a chain of single-bit stages that moves its contents along by one stage each time a shift command is issued. One stage is the entry stage. It takes a serial data bit. Every other stage inside the active length takes the value of its upstream neighbour. The bit pushed past the far end of the active length is not lost: it is kept in an unload flag. All stages are visible in parallel, one output per stage, so each stage can drive its own downstream load.

Each command has its own input. A shift command acts on the rising edge of its level, so a held request moves the data only once. A load command writes the data bit straight into the entry stage without moving anything. A clear command zeroes the array.

The active length comes from a signed input and can be shorter than the physical array. The shift direction can be chosen at run time. A small status group reports four things:
- that the block is enabled;
- a one-cycle completion pulse after each shift;
- an error when the length is not usable;
- the last bit that was unloaded.

Top module: `bit_shift_reg`

## Requirements
- R1: During and after reset, before any command, `q_o`, `unl_o`, `dn_o`, `err_o` and `en_o` are all 0.
- R2: With `dir_i`=0, an accepted shift moves `data_i` into stage 1 (`q_o[0]`). Each active stage k>1 takes the old value of stage k-1. The old value of the last active stage (`q_o[len-1]`) is stored in `unl_o`. All of this is visible the cycle after the shift edge. Example: stages 1..8 = 10110010 with data 0 become 01011001, and `unl_o`=0.
- R3: With `dir_i`=1, an accepted shift moves `data_i` into the last active stage (`q_o[len-1]`). Each other active stage k takes the old value of stage k+1. The old `q_o[0]` is stored in `unl_o`.
- R4: Stages at or beyond the active length (`q_o[k]`, k >= len) keep their value through a shift.
- R5: A shift is accepted only on a 0-to-1 change of `shift_i` between consecutive clock edges. Holding `shift_i` high moves the data once. A level already high when reset is released does not count as a change.
- R6: `clear_i` zeroes every stage, `unl_o` and `dn_o` on the next edge. It takes precedence over a shift or a load in the same cycle.
- R7: `load_i` writes `data_i` into the entry stage only. The entry stage is `q_o[0]` when `dir_i`=0 and `q_o[len-1]` when `dir_i`=1. If a shift is accepted in the same cycle, the load is ignored.
- R8: `dn_o` is 1 for exactly the one cycle after an accepted shift, and 0 otherwise.
- R9: `len_i` is a two's complement value. A length below 1 (negative or zero) or above WIDTH sets `err_o` the cycle after. While the length is illegal, shifts and loads are not performed.
- R10: `en_o` follows `enable_i` one cycle later. While `enable_i` is 0, shifts and loads have no effect (clear still acts).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Allows shift and load commands |
| clear_i | input | 1 | Synchronous clear of stages and unload flag |
| shift_i | input | 1 | Shift request, acted on at its rising edge |
| load_i | input | 1 | Write data bit into the entry stage |
| data_i | input | 1 | Serial data bit |
| dir_i | input | 1 | 0: toward higher stages, 1: toward stage 1 |
| len_i | input | LEN_W | Active length, signed |
| q_o | output | WIDTH | Parallel stage outputs, bit 0 is stage 1 |
| unl_o | output | 1 | Last bit shifted out |
| en_o | output | 1 | Enabled status |
| dn_o | output | 1 | Shift completion pulse |
| err_o | output | 1 | Illegal length status |

## Verification
The functions that collide are a shift edge and a clear or a load arriving at the same clock edge, and a shift edge arriving while the length is illegal or the block is disabled. The bench provokes these deliberately in directed steps. It also lets constrained random traffic land them together frequently. A cycle-accurate bench model applies the stated precedence: clear first, then the length and enable gates, then shift over load. Every output is compared against that model on every cycle.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} dir_e;

  function automatic logic len_bad(input int len, input int width);
    return (len < 1) || (len > width);
  endfunction
endpackage

// File: rtl/bsr_edge.sv
module bsr_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic rise_o
);
  logic prev_q;

  // reset to 1: a level already high at release is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/bsr_stages.sv
module bsr_stages #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned IDX_W = $clog2(WIDTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             shift_i,
  input  logic             load_i,
  input  bsr_pkg::dir_e    dir_i,
  input  logic             din_i,
  input  logic [IDX_W-1:0] len_i,
  output logic [WIDTH-1:0] q_o,
  output logic             out_bit_o
);
  logic [IDX_W-1:0] last_idx;
  assign last_idx = len_i - IDX_W'(1);

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    localparam logic [IDX_W-1:0] IDX = IDX_W'(i);
    logic stage_q, up_src, dn_src, active, is_entry;

    if (i == 0) begin : g_first
      assign up_src = din_i;
    end else begin : g_mid
      assign up_src = q_o[i-1];
    end

    if (i == WIDTH - 1) begin : g_top
      assign dn_src = din_i;
    end else begin : g_low
      assign dn_src = (IDX == last_idx) ? din_i : q_o[i+1];
    end

    assign active   = IDX < len_i;
    assign is_entry = (dir_i == bsr_pkg::DIR_UP) ? (i == 0) : (IDX == last_idx);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  stage_q <= 1'b0;
      else if (clear_i)             stage_q <= 1'b0;
      else if (shift_i && active)   stage_q <= (dir_i == bsr_pkg::DIR_UP) ? up_src : dn_src;
      else if (load_i && is_entry)  stage_q <= din_i;
    end

    assign q_o[i] = stage_q;
  end

  always_comb begin
    out_bit_o = 1'b0;
    if (dir_i == bsr_pkg::DIR_DOWN) begin
      out_bit_o = q_o[0];
    end else begin
      for (int k = 0; k < WIDTH; k++)
        if (IDX_W'(k) == last_idx) out_bit_o = q_o[k];
    end
  end
endmodule

// File: rtl/bsr_status.sv
module bsr_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic enable_i,
  input  logic shift_done_i,
  input  logic out_bit_i,
  input  logic len_bad_i,
  output logic en_o,
  output logic dn_o,
  output logic err_o,
  output logic unl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= 1'b0;
      dn_o  <= 1'b0;
      err_o <= 1'b0;
      unl_o <= 1'b0;
    end else begin
      en_o  <= enable_i;
      err_o <= len_bad_i;
      dn_o  <= shift_done_i & ~clear_i;
      if (clear_i)           unl_o <= 1'b0;
      else if (shift_done_i) unl_o <= out_bit_i;
    end
  end
endmodule

// File: rtl/bit_shift_reg.sv
module bit_shift_reg #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned LEN_W = $clog2(WIDTH + 1) + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    enable_i,
  input  logic                    clear_i,
  input  logic                    shift_i,
  input  logic                    load_i,
  input  logic                    data_i,
  input  logic                    dir_i,
  input  logic signed [LEN_W-1:0] len_i,
  output logic [WIDTH-1:0]        q_o,
  output logic                    unl_o,
  output logic                    en_o,
  output logic                    dn_o,
  output logic                    err_o
);
  localparam int unsigned IDX_W = $clog2(WIDTH + 1);

  logic             shift_rise, bad_len, shift_go, load_go, out_bit;
  logic [IDX_W-1:0] len_u;
  bsr_pkg::dir_e    dir;

  assign dir      = bsr_pkg::dir_e'(dir_i);
  assign bad_len  = bsr_pkg::len_bad(int'(len_i), int'(WIDTH));
  assign len_u    = len_i[IDX_W-1:0];
  assign shift_go = shift_rise & enable_i & ~clear_i & ~bad_len;
  assign load_go  = load_i & enable_i & ~clear_i & ~bad_len & ~shift_go;

  bsr_edge u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (shift_i),
    .rise_o  (shift_rise)
  );

  bsr_stages #(.WIDTH(WIDTH)) u_stages (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear_i),
    .shift_i   (shift_go),
    .load_i    (load_go),
    .dir_i     (dir),
    .din_i     (data_i),
    .len_i     (len_u),
    .q_o       (q_o),
    .out_bit_o (out_bit)
  );

  bsr_status u_status (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (clear_i),
    .enable_i     (enable_i),
    .shift_done_i (shift_go),
    .out_bit_i    (out_bit),
    .len_bad_i    (bad_len),
    .en_o         (en_o),
    .dn_o         (dn_o),
    .err_o        (err_o),
    .unl_o        (unl_o)
  );
endmodule

// File: rtl/bit_shift_reg_chk.sv
module bit_shift_reg_chk #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned LEN_W = $clog2(WIDTH + 1) + 1
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    enable_i,
  input logic                    clear_i,
  input logic                    shift_i,
  input logic                    load_i,
  input logic                    data_i,
  input logic                    dir_i,
  input logic signed [LEN_W-1:0] len_i,
  input logic [WIDTH-1:0]        q_o,
  input logic                    unl_o,
  input logic                    en_o,
  input logic                    dn_o,
  input logic                    err_o
);
  logic illegal;
  assign illegal = (int'(len_i) < 1) || (int'(len_i) > int'(WIDTH));

  p_clear_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (q_o == '0) && !unl_o && !dn_o);

  p_dn_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_o |=> !dn_o);

  p_held_shift_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && $past(shift_i)) |=> !dn_o);

  p_bad_len_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (illegal && !clear_i) |=> $stable(q_o) && !dn_o && err_o);

  p_disabled_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !clear_i) |=> $stable(q_o) && !dn_o && !en_o);

  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (q_o == '0) && !unl_o && !dn_o && !err_o && !en_o);
endmodule

bind bit_shift_reg bit_shift_reg_chk #(.WIDTH(WIDTH), .LEN_W(LEN_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .clear_i(clear_i),
  .shift_i(shift_i), .load_i(load_i), .data_i(data_i), .dir_i(dir_i),
  .len_i(len_i), .q_o(q_o), .unl_o(unl_o), .en_o(en_o), .dn_o(dn_o),
  .err_o(err_o)
);

// File: tb/bit_shift_reg_tb.sv
module bit_shift_reg_tb;
  localparam int W = 8;
  localparam int LW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, clear = 1'b0, shift = 1'b0, load = 1'b0, data = 1'b0, dir = 1'b0;
  logic signed [LW-1:0] len = LW'(W);
  logic [W-1:0] q;
  logic unl, en, dn, err;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] m_q = '0;
  logic m_unl = 0, m_en = 0, m_dn = 0, m_err = 0, m_prev = 1;

  always #2 clk = ~clk;

  bit_shift_reg #(.WIDTH(W), .LEN_W(LW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .clear_i(clear),
    .shift_i(shift), .load_i(load), .data_i(data), .dir_i(dir), .len_i(len),
    .q_o(q), .unl_o(unl), .en_o(en), .dn_o(dn), .err_o(err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bench model derived from R2..R10
  task automatic model_tick();
    logic rise, bad, go;
    logic [W-1:0] nq;
    int L;
    L    = int'(len);
    rise = shift && !m_prev;
    m_prev = shift;
    bad  = (L < 1) || (L > W);
    go   = rise && enable && !bad && !clear;
    nq   = m_q;
    if (clear) begin
      nq = '0; m_unl = 0; m_dn = 0;
    end else if (go) begin
      if (!dir) begin
        m_unl = m_q[L-1];
        for (int k = L - 1; k > 0; k--) nq[k] = m_q[k-1];
        nq[0] = data;
      end else begin
        m_unl = m_q[0];
        for (int k = 0; k < L - 1; k++) nq[k] = m_q[k+1];
        nq[L-1] = data;
      end
      m_dn = 1;
    end else begin
      m_dn = 0;
      if (load && enable && !bad) begin
        if (!dir) nq[0] = data;
        else      nq[L-1] = data;
      end
    end
    m_q   = nq;
    m_en  = enable;
    m_err = bad;
  endtask

  task automatic step();
    @(posedge clk);
    model_tick();
    @(negedge clk);
    chk("R2/R3/R4 q_o", 32'(q), 32'(m_q));
    chk("R2 unl_o", 32'(unl), 32'(m_unl));
    chk("R8 dn_o", 32'(dn), 32'(m_dn));
    chk("R9 err_o", 32'(err), 32'(m_err));
    chk("R10 en_o", 32'(en), 32'(m_en));
  endtask

  task automatic pulse_shift(input logic d);
    data = d; shift = 1; step();
    shift = 0; step();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0] seq;
    void'($urandom(32'd1234));
    #10;
    @(negedge clk);
    // R1: reset state
    chk("R1 q_o", 32'(q), 0);
    chk("R1 flags", {unl, en, dn, err}, 0);
    rst_n = 1;
    enable = 1;
    step();

    // R2: build stages 1..8 = 10110010, then shift in 0
    seq = 8'b0100_1101;
    for (int i = 7; i >= 0; i--) pulse_shift(seq[i]);
    chk("R2 pattern", 32'(q), 32'h4D);
    data = 0; shift = 1; step();
    chk("R2 shifted", 32'(q), 32'h9A);
    chk("R2 unload", 32'(unl), 0);
    chk("R8 pulse set", 32'(dn), 1);
    shift = 0; step();
    chk("R8 pulse clear", 32'(dn), 0);

    // R6: clear together with shift edge and load
    clear = 1; shift = 1; load = 1; data = 1; step();
    chk("R6 clear wins", 32'(q), 0);
    clear = 0; shift = 0; load = 0; step();

    // R3: reverse, full length, entry at top stage
    dir = 1; pulse_shift(1);
    chk("R3 entry top", 32'(q), 32'h80);
    // R7 and R4: forward, length 4
    dir = 0; len = 4;
    data = 1; load = 1; step(); load = 0;
    chk("R7 load", 32'(q), 32'h81);
    pulse_shift(0); chk("R4 step1", 32'(q), 32'h82);
    pulse_shift(0); chk("R4 step2", 32'(q), 32'h84);
    pulse_shift(0); chk("R4 step3", 32'(q), 32'h88);
    data = 0; shift = 1; step();
    chk("R4 out", 32'(q), 32'h80);
    chk("R2 unl last", 32'(unl), 1);
    shift = 0; step();
    // R7: load ignored when shift accepted same cycle
    data = 1; load = 1; shift = 1; step(); load = 0;
    chk("R7 shift over load", 32'(q), 32'h81);
    shift = 0; step();
    // R3: reverse with length 4, out from stage 1
    dir = 1; pulse_shift(0);
    chk("R3 reverse", 32'(q), 32'h80);
    chk("R3 unl", 32'(unl), 1);

    // R5: held shift moves once
    dir = 0; data = 1; shift = 1;
    step(); step(); step();
    chk("R5 held", 32'(q), 32'h81);
    chk("R5 no repeat dn", 32'(dn), 0);
    shift = 0; step();

    // R9: illegal lengths
    len = -1; pulse_shift(1);
    chk("R9 negative", 32'(q), 32'h81);
    chk("R9 err", 32'(err), 1);
    len = 0; pulse_shift(1);
    chk("R9 zero", 32'(q), 32'h81);
    len = 9; data = 0; load = 1; step(); load = 0;
    chk("R9 too long", 32'(q), 32'h81);
    len = 8; step();
    chk("R9 err clear", 32'(err), 0);

    // R10: disabled
    enable = 0; pulse_shift(1);
    chk("R10 disabled", 32'(q), 32'h81);
    chk("R10 en_o", 32'(en), 0);
    enable = 1; step();

    // random mix
    for (int n = 0; n < 4000; n++) begin
      shift  = ($urandom_range(0, 1) == 1);
      data   = ($urandom_range(0, 1) == 1);
      load   = ($urandom_range(0, 4) == 0);
      clear  = ($urandom_range(0, 19) == 0);
      enable = ($urandom_range(0, 9) != 0);
      if ($urandom_range(0, 9) == 0) dir = ~dir;
      if ($urandom_range(0, 15) == 0) len = LW'($urandom_range(0, 12)) - LW'(2);
      step();
    end
    finish_run();
  end
endmodule